// File: doc/BRIEF.md
# Strobed Serial Register-Access Slave

This block is the device end of a four-wire register bus that a host drives by toggling pins from software. The wires are an active-low frame clear, a strobe, a host-to-device data line and a device-to-host data line. The block samples all three incoming pins on its own system clock. After a clear pulse it takes an 8-bit command and then moves one 16-bit word, either into the block or out of it.

The block holds two fixed identification words and eight 16-bit control registers. Downstream pad, multiplexing and indicator logic uses the control registers; that logic is not part of this block. Each address has its own read and write permission. Identification words can be read but not written. Control words can be read and written. Any other address reads as zero and ignores writes. After a frame has moved its word, the block ignores further strobe edges until the next clear. This protects the registers when the host leaves the strobe high between transactions.

Top module: `strobeRegSlave`

## Requirements
- R1: While the synchronized clear line is low, the block abandons the current frame, returns to the command phase and drives dataOut low. A partly sent command or data word has no effect on any register.
- R2: The command is 8 bits, sent most significant bit first, each bit captured on a rising strobe edge. The first bit is the direction flag (1 = read, 0 = write). The remaining seven bits are the register address, most significant bit first.
- R3: In a write, the 16 data bits after the command are captured most significant bit first. The target register changes only on the 16th captured bit, and it takes exactly those 16 bits.
- R4: In a read, dataOut carries bit 15 of the addressed word once the first data-phase strobe pulse is complete, bit 15-k after pulse k+1, and bit 0 after the 16th pulse.
- R5: Strobe edges after a frame has moved its word are ignored until the next clear. So are all strobe edges after the system reset and before the first clear.
- R6: Address 0x00 holds a read-only platform word whose low byte is the maker code 0x01 (default word 0x0A01).
- R7: Address 0x01 holds a read-only firmware word packed as build[15:12], major[11:8], minor[7:4], patch[3:0], with major equal to 0 (default word 0x3012).
- R8: Addresses 0x08-0x09 (function enables), 0x10-0x12 (pad enables) and 0x18-0x1A (pad directions) are 16-bit read/write registers that the system reset clears to zero.
- R9: A write to 0x00, 0x01 or any address not listed in R8 changes no register.
- R10: A read of any address not listed in R6, R7 or R8 returns 16 zero bits.
- R11: Clear, strobe and data-in pass through SYNC_STAGES flip-flops before use. Every register or shift action happens on a detected rising strobe edge, one action per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the fastest strobe toggle rate |
| rstN | input | 1 | Asynchronous active-low system reset |
| clearN | input | 1 | Asynchronous active-low frame clear from the host |
| strobe | input | 1 | Asynchronous bit strobe from the host |
| dataIn | input | 1 | Asynchronous host-to-device serial data |
| dataOut | output | 1 | Device-to-host serial data, registered |

## Verification
The assertions assume the host holds each strobe level, and each clear pulse, for at least four system clocks. They also assume dataIn is settled before the strobe rises. Under those conditions every synchronized rising edge reaches the control logic as exactly one single-cycle event, with valid data beside it. The stimulus keeps within these limits: every pin level lasts four clocks, and dataIn changes one full half-period before the strobe rises. The stimulus also deliberately sends strobe pulses outside a frame, and clears in the middle of a frame, to exercise R1 and R5.

// File: rtl/strobeRegPkg.sv
package strobeRegPkg;

  localparam int CMD_ADDR_W = 7;
  localparam int WORD_W     = 16;
  localparam int N_CTRL     = 8;
  localparam int SLOT_W     = $clog2(N_CTRL);

  localparam int ADDR_PLATFORM = 0;
  localparam int ADDR_FIRMWARE = 1;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_WR, PH_RD} phase_t;

  // one-cycle actions issued by the frame control to the datapath
  typedef struct packed {
    logic frameReset;
    logic shiftBit;
    logic latchAddr;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } ctlStrobes_t;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  // maps a bus address to a control register slot
  function automatic slot_t ctrlSlot(input logic [CMD_ADDR_W-1:0] a);
    slot_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (a)
      7'h08: s.idx = 3'd0;
      7'h09: s.idx = 3'd1;
      7'h10: s.idx = 3'd2;
      7'h11: s.idx = 3'd3;
      7'h12: s.idx = 3'd4;
      7'h18: s.idx = 3'd5;
      7'h19: s.idx = 3'd6;
      7'h1A: s.idx = 3'd7;
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pinSync.sv
module pinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clearN,
  input  logic strobe,
  input  logic dataIn,
  output logic clrS,
  output logic dinS,
  output logic rise
);
  // bit order inside each stage: {data, strobe, clear}
  localparam logic [2:0] IDLE_LEVELS = 3'b011;

  logic [STAGES-1:0][2:0] chain;
  logic strobeLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain      <= {STAGES{IDLE_LEVELS}};
      strobeLast <= 1'b1;
    end else begin
      chain      <= {chain[STAGES-2:0], {dataIn, strobe, clearN}};
      strobeLast <= chain[STAGES-1][1];
    end
  end

  assign clrS = chain[STAGES-1][0];
  assign dinS = chain[STAGES-1][2];
  assign rise = chain[STAGES-1][1] & ~strobeLast;

endmodule

// File: rtl/frameCtrl.sv
module frameCtrl
  import strobeRegPkg::*;
#(
  parameter int ADDR_W = CMD_ADDR_W,
  parameter int DATA_W = WORD_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrS,
  input  logic        rise,
  input  logic        dinS,
  output ctlStrobes_t ctl
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int MAXN  = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W = $clog2(MAXN);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             readFlag;

  always_comb begin
    ctl = '0;
    if (!clrS) begin
      ctl.frameReset = 1'b1;
    end else if (rise) begin
      case (phase)
        PH_CMD: begin
          if (bitCnt == CMD_LAST) begin
            ctl.latchAddr = 1'b1;
            ctl.loadRead  = readFlag;
          end else begin
            ctl.shiftBit = 1'b1;
          end
        end
        PH_WR: begin
          if (bitCnt == DATA_LAST) ctl.commit = 1'b1;
          else                     ctl.shiftBit = 1'b1;
        end
        PH_RD:   ctl.shiftOut = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      readFlag <= 1'b0;
    end else if (!clrS) begin
      phase  <= PH_CMD;
      bitCnt <= '0;
    end else if (rise) begin
      case (phase)
        PH_CMD: begin
          if (bitCnt == '0) readFlag <= dinS;
          if (bitCnt == CMD_LAST) begin
            bitCnt <= '0;
            phase  <= readFlag ? PH_RD : PH_WR;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        PH_WR, PH_RD: begin
          if (bitCnt == DATA_LAST) begin
            bitCnt <= '0;
            phase  <= PH_IDLE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regDatapath.sv
module regDatapath
  import strobeRegPkg::*;
#(
  parameter int               ADDR_W        = CMD_ADDR_W,
  parameter int               DATA_W        = WORD_W,
  parameter logic [DATA_W-1:0] PLATFORM_WORD = 16'h0A01,
  parameter logic [DATA_W-1:0] FIRMWARE_WORD = 16'h3012
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic        dinS,
  output logic        dataOut
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] wrWord;
  logic [DATA_W-1:0] rdWord;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] ctrlReg [N_CTRL];
  slot_t             rdSlot;
  slot_t             wrSlot;

  assign nextAddr = {shreg[ADDR_W-2:0], dinS};
  assign wrWord   = {shreg[DATA_W-2:0], dinS};

  always_comb begin
    rdSlot = ctrlSlot(nextAddr);
    wrSlot = ctrlSlot(addrQ);
    rdWord = '0;
    if (nextAddr == ADDR_W'(ADDR_PLATFORM))      rdWord = PLATFORM_WORD;
    else if (nextAddr == ADDR_W'(ADDR_FIRMWARE)) rdWord = FIRMWARE_WORD;
    else if (rdSlot.hit)                         rdWord = ctrlReg[rdSlot.idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      addrQ   <= '0;
      dataOut <= 1'b0;
    end else begin
      if (ctl.frameReset)     shreg <= '0;
      else if (ctl.shiftBit)  shreg <= wrWord;
      else if (ctl.latchAddr) shreg <= ctl.loadRead ? rdWord : '0;
      else if (ctl.shiftOut)  shreg <= {shreg[DATA_W-2:0], 1'b0};

      if (ctl.latchAddr) addrQ <= nextAddr;

      if (ctl.frameReset)    dataOut <= 1'b0;
      else if (ctl.shiftOut) dataOut <= shreg[DATA_W-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < N_CTRL; g++) ctrlReg[g] <= '0;
    end else if (ctl.commit && wrSlot.hit) begin
      ctrlReg[wrSlot.idx] <= wrWord;
    end
  end

endmodule

// File: rtl/strobeRegSlave.sv
module strobeRegSlave
  import strobeRegPkg::*;
#(
  parameter int               ADDR_W        = CMD_ADDR_W,
  parameter int               DATA_W        = WORD_W,
  parameter int               SYNC_STAGES   = 2,
  parameter logic [DATA_W-1:0] PLATFORM_WORD = 16'h0A01,
  parameter logic [DATA_W-1:0] FIRMWARE_WORD = 16'h3012  // build 3, major 0, minor 1, patch 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clearN,
  input  logic strobe,
  input  logic dataIn,
  output logic dataOut
);
  logic        clrS;
  logic        dinS;
  logic        strobeRise;
  ctlStrobes_t ctl;

  pinSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .clearN(clearN), .strobe(strobe), .dataIn(dataIn),
    .clrS(clrS), .dinS(dinS), .rise(strobeRise)
  );

  frameCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clrS(clrS), .rise(strobeRise), .dinS(dinS), .ctl(ctl)
  );

  regDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PLATFORM_WORD(PLATFORM_WORD), .FIRMWARE_WORD(FIRMWARE_WORD)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dinS(dinS), .dataOut(dataOut)
  );

endmodule

// File: rtl/strobeRegSlaveChk.sv
module strobeRegSlaveChk
  import strobeRegPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        clrS,
  input logic        rise,
  input ctlStrobes_t ctl,
  input logic        dataOut
);
  AST_CLEAR_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !clrS |-> (ctl.frameReset && !ctl.commit && !ctl.shiftOut && !ctl.shiftBit)); // R1

  AST_CLEAR_ZEROES_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.frameReset |=> (dataOut == 1'b0)); // R1

  AST_LOAD_WITH_ADDRESS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRead |-> ctl.latchAddr); // R2

  AST_ACTION_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftBit || ctl.latchAddr || ctl.shiftOut || ctl.commit) |-> rise); // R11

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.shiftBit, ctl.latchAddr, ctl.shiftOut, ctl.commit})); // R3

  AST_OUTPUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shiftOut && !ctl.frameReset) |=> $stable(dataOut)); // R4
endmodule

bind strobeRegSlave strobeRegSlaveChk uChk (
  .clk(clk), .rstN(rstN), .clrS(clrS), .rise(strobeRise), .ctl(ctl), .dataOut(dataOut)
);

// File: tb/tb_strobeRegSlave.sv
module tb_strobeRegSlave;
  localparam int H = 4;                 // clocks per pin level
  localparam logic [15:0] PLAT = 16'h0A01;
  localparam logic [15:0] FW   = 16'h3012;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearN = 1'b1;
  logic strobe = 1'b1;
  logic dataIn = 1'b0;
  logic dataOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [128];

  always #4 clk = ~clk;                 // 125 MHz

  strobeRegSlave dut (
    .clk(clk), .rstN(rstN), .clearN(clearN), .strobe(strobe),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic bit isCtl(input int a);
    return (a == 8) || (a == 9) || (a >= 16 && a <= 18) || (a >= 24 && a <= 26);
  endfunction

  function automatic logic [15:0] expVal(input int a);
    if (a == 0) return PLAT;
    if (a == 1) return FW;
    if (isCtl(a)) return model[a];
    return 16'h0000;
  endfunction

  function automatic logic [15:0] pat(input int a);
    logic [6:0] b = 7'(a);
    return {b, 1'b1, ~b, 1'b0} ^ 16'h5A3C;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic doClear();
    clearN = 1'b0; hold(H);
    clearN = 1'b1; hold(H);
  endtask

  task automatic sendBits(input int n, input logic [15:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      strobe = 1'b0;
      dataIn = v[i];
      hold(H);
      strobe = 1'b1;
      hold(H);
    end
  endtask

  task automatic sendCmd(input bit rd, input int a);
    sendBits(8, {8'h00, rd, 7'(a)});
    strobe = 1'b0; hold(H);
  endtask

  task automatic sendData(input int n, input logic [15:0] d);
    for (int i = n - 1; i >= 0; i--) begin
      dataIn = d[i]; hold(H);
      strobe = 1'b1; hold(H);
      strobe = 1'b0;
    end
    hold(H);
    strobe = 1'b1; hold(H);
  endtask

  task automatic writeRaw(input int a, input logic [15:0] d);
    sendCmd(1'b0, a);
    sendData(16, d);
  endtask

  task automatic writeReg(input int a, input logic [15:0] d);
    doClear();
    writeRaw(a, d);
    if (isCtl(a)) model[a] = d;
  endtask

  task automatic readReg(input int a, output logic [15:0] d);
    doClear();
    sendCmd(1'b1, a);
    d = '0;
    for (int i = 15; i >= 0; i--) begin
      strobe = 1'b1; hold(H);
      strobe = 1'b0; hold(H);
      d[i] = dataOut;
    end
    strobe = 1'b1; hold(H);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    for (int a = 0; a < 128; a++) model[a] = 16'h0000;
    hold(5);
    check("R1 reset output", {15'h0, dataOut}, 16'h0000);
    rstN = 1'b1;
    hold(H);

    // R5: a full write frame before any clear must be ignored
    writeRaw(8, 16'hFFFF);
    readReg(8, rd);
    check("R5 pre-clear write ignored", rd, 16'h0000);

    // R6 R7 R8 R10: reset values across the whole address space
    for (int a = 0; a < 128; a++) begin
      readReg(a, rd);
      if (a == 0)        check("R6 platform word", rd, PLAT);
      else if (a == 1)   check("R7 firmware word", rd, FW);
      else if (isCtl(a)) check("R8 reset zero", rd, 16'h0000);
      else               check("R10 unlisted read", rd, 16'h0000);
      if (a == 0) check("R6 maker code", {8'h00, rd[7:0]}, 16'h0001);
      if (a == 1) check("R7 major field", {12'h000, rd[11:8]}, 16'h0000);
    end

    // R3 R9: write every address, then read every address back
    for (int a = 0; a < 128; a++) writeReg(a, pat(a));
    for (int a = 0; a < 128; a++) begin
      readReg(a, rd);
      if (isCtl(a))  check("R3 R8 write readback", rd, expVal(a));
      else if (a < 2) check("R9 id write ignored", rd, expVal(a));
      else           check("R9 R10 unlisted write ignored", rd, 16'h0000);
    end

    // R3: complement on every control register flips all bits
    for (int a = 0; a < 128; a++) if (isCtl(a)) writeReg(a, ~pat(a));
    for (int a = 0; a < 128; a++) if (isCtl(a)) begin
      readReg(a, rd);
      check("R3 inverted readback", rd, expVal(a));
    end

    // R1: clear during a command, then a clean write
    doClear();
    sendBits(3, 16'h0004);
    writeReg(16, 16'h1234);
    readReg(16, rd);
    check("R1 abort in command", rd, 16'h1234);
    readReg(9, rd);
    check("R1 abort in command side effect", rd, expVal(9));

    // R1: clear in the middle of a write data phase
    doClear();
    sendCmd(1'b0, 17);
    for (int i = 0; i < 8; i++) begin
      dataIn = 1'b1; hold(H);
      strobe = 1'b1; hold(H);
      strobe = 1'b0; hold(H);
    end
    doClear();
    readReg(17, rd);
    check("R1 abort in data", rd, expVal(17));

    // R5: strobe activity after a finished write frame
    writeReg(18, 16'hBEEF);
    writeRaw(18, 16'h0000);
    readReg(18, rd);
    check("R5 trailing write ignored", rd, 16'hBEEF);

    // R5: strobe activity after a finished read frame
    writeRaw(24, 16'h0F0F);
    readReg(24, rd);
    check("R5 trailing after read", rd, expVal(24));

    // R4 R11: walking one through a register, checks bit order both ways
    for (int k = 0; k < 16; k++) begin
      writeReg(25, 16'h0001 << k);
      readReg(25, rd);
      check("R4 R11 walking bit", rd, 16'h0001 << k);
    end

    // R2: address 0x1A and 0x1B differ only in the last address bit
    writeReg(26, 16'hC3A5);
    writeReg(27, 16'h7777);
    readReg(26, rd);
    check("R2 address lsb", rd, 16'hC3A5);

    summary();
    $finish;
  end
endmodule